// File: doc/BRIEF.md
# Clause-22 Management Command Engine

This block runs single read or write transactions on a clause-22 serial management bus toward Ethernet PHYs. A host sees two 16-bit registers behind a one-bit address: a control word and a data word. One write of the control word carries the whole command: the direction, a 5-bit PHY address and a 5-bit register number. That write starts a complete 64-bit frame on the management clock and data lines.

For a write, the host first loads the data word. The engine then shifts that value out after the address fields. For a read, the engine releases the data line at the turnaround and samples the 16 bits the PHY returns on the rising clock edges. It places the result in the data word when the frame ends.

The host polls an idle flag in the control word to learn when the engine is free again. No interrupt is raised. The management clock is derived from the system clock by a parameterised half-period count. With the default count of 10 at 50 MHz the period is 400 ns.

Top module: `mdio_cmd_engine`

## Requirements
- R1: A host write to the control word (host_addr = 0) while idle launches a transfer. Bit 15 of the control word reads 1 when idle, reads 0 from the cycle after the launching write, and reads 1 again when the frame has ended.
- R2: In the control word, bit 13 selects the direction (1 = write, 0 = read), bits 12:8 carry the PHY address and bits 4:0 carry the register number. Bits 15:14 and 7:5 of a written word are ignored. The control word reads back as {idle, 0, direction, PHY address, 000, register number} of the last accepted command.
- R3: Each frame carries, MSB first, 32 ones, start bits 01, an opcode (01 for write, 10 for read), the PHY address, the register number, two turnaround bits and 16 data bits. In a write frame the turnaround is 10 and the data is the data word as it stood at launch.
- R4: mdio_o changes only after a falling MDC edge, so it is stable at every rising edge. mdio_oe is high for all 64 bits of a write frame and for the first 46 bits of a read frame. mdio_oe is low for the read turnaround and the read data bits, and low whenever the engine is idle.
- R5: In a read, the PHY's 16 data bits are sampled on the rising MDC edges of frame bits 48 to 63, MSB first. They are readable in the data word (host_addr = 1) once the idle flag is back.
- R6: MDC rests low while idle. During a transfer each of its high and low phases lasts exactly MDC_HALF system clocks, which gives a 400 ns period with the defaults.
- R7: A transfer holds the engine busy for exactly 128 × MDC_HALF system clocks, counted from the clock edge that accepts the launching write.
- R8: A control word write that arrives while busy is ignored. The frame in progress and the stored command are unchanged.
- R9: A data word write (host_addr = 1) is stored and read back while idle, and is ignored while busy. The data word resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 1 | Register select: 0 control word, 1 data word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the register selected by host_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o; low releases the line |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
Several rules are checked on every cycle against the live design. A control write while idle must raise busy on the next cycle. The bus must be released with MDC low whenever idle. Every MDC phase must last exactly the configured half period. The stored command must not move while busy. The data word may change only after an idle host write or at the end of a frame.

The exact bit content of write and read frames needs the bench's PHY responder, and so does the turnaround release window and the value captured from the PHY. The bench also checks the total transfer length measured from the host side, and that writes arriving mid-frame leave no trace.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  localparam int IDLE_BIT = 15;
  localparam int OP_BIT   = 13;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e   op;
    logic [4:0] phy;
    logic [4:0] regad;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c, logic [15:0] d);
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] dd;
    if (c.op == OP_WRITE) begin
      opc = 2'b01;
      ta  = 2'b10;
      dd  = d;
    end else begin
      opc = 2'b10;
      ta  = 2'b00;
      dd  = 16'h0000;
    end
    return {{PRE_BITS{1'b1}}, 2'b01, opc, c.phy, c.regad, ta, dd};
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  always_comb begin
    wrap = run && (cnt_q == LAST);
    rise = wrap && !mdc_q;
    fall = wrap && mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
      mdc_d = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] cap
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] IDX_TA   = IW'(TA_FIRST);
  localparam logic [IW-1:0] IDX_DATA = IW'(DATA_FIRST);

  logic                  busy_q, busy_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  mdio_op_e              op_q, op_d;
  logic [15:0]           cap_q, cap_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    op_d   = op_q;
    cap_d  = cap_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = '0;
        sh_d   = build_frame(cmd, wdata);
        op_d   = cmd.op;
      end
    end else begin
      if (rise && (op_q == OP_READ) && (idx_q >= IDX_DATA))
        cap_d = {cap_q[14:0], mdio_i};
      if (fall) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          idx_d = idx_q + IW'(1);
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      op_q   <= OP_READ;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      op_q   <= op_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !((op_q == OP_READ) && (idx_q >= IDX_TA));
  assign cap     = cap_q;

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_addr,
  input  logic [15:0] host_wdata,
  input  logic        busy,
  input  logic        done,
  input  logic [15:0] cap,
  output logic        start,
  output mdio_cmd_t   launch_cmd,
  output mdio_cmd_t   cmd_q,
  output logic [15:0] data_q,
  output logic [15:0] host_rdata
);
  mdio_cmd_t   cmd_d;
  logic [15:0] data_d;

  always_comb begin
    launch_cmd.op    = mdio_op_e'(host_wdata[OP_BIT]);
    launch_cmd.phy   = host_wdata[12:8];
    launch_cmd.regad = host_wdata[4:0];
    start  = host_wr && (host_addr == SEL_CTRL) && !busy;
    cmd_d  = start ? launch_cmd : cmd_q;
    data_d = data_q;
    if (done && (cmd_q.op == OP_READ))
      data_d = cap;
    else if (host_wr && (host_addr == SEL_DATA) && !busy)
      data_d = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    if (host_addr == SEL_CTRL)
      host_rdata = {!busy, 1'b0, cmd_q.op, cmd_q.phy, 3'b000, cmd_q.regad};
    else
      host_rdata = data_q;
  end

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        busy;
  logic        done;
  logic        start;
  logic        rise;
  logic        fall;
  logic [15:0] cap;
  logic [15:0] data_q;
  mdio_cmd_t   launch_cmd;
  mdio_cmd_t   cmd_q;
  logic [10:0] cmd_bits;

  assign cmd_bits = cmd_q;

  mdio_host_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .done       (done),
    .cap        (cap),
    .start      (start),
    .launch_cmd (launch_cmd),
    .cmd_q      (cmd_q),
    .data_q     (data_q),
    .host_rdata (host_rdata)
  );

  mdio_clkdiv #(.HALF(MDC_HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .mdc   (mdc),
    .rise  (rise),
    .fall  (fall)
  );

  mdio_frame_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmd     (launch_cmd),
    .wdata   (data_q),
    .rise    (rise),
    .fall    (fall),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .done    (done),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .cap     (cap)
  );

endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
  parameter int HALF = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        host_wr,
  input logic        host_addr,
  input logic [10:0] cmd_bits,
  input logic [15:0] data_reg
);
  logic        mdc_q;
  logic [15:0] hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      hc    <= '0;
    end else begin
      mdc_q <= mdc;
      if (!busy)
        hc <= '0;
      else if (mdc != mdc_q)
        hc <= 16'd1;
      else if (hc != 16'hFFFF)
        hc <= hc + 16'd1;
    end
  end

  a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_wr && (host_addr == 1'b0)) |=> busy);

  a_r4_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  a_r6_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mdc != mdc_q)) |-> (hc == 16'(HALF)));

  a_r7_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdc);

  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_bits));

  a_r9_data_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_reg) |-> ($past(done) || $past(!busy && host_wr && host_addr)));

endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(.HALF(MDC_HALF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .cmd_bits  (cmd_bits),
  .data_reg  (data_q)
);

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
  localparam int HALF       = 10;
  localparam int TXN_CYCLES = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_addr = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #10 clk = ~clk;

  mdio_cmd_engine #(.MDC_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;
  logic [63:0] cap_bits;
  logic [63:0] cap_oe;
  int          nrise = 0;
  logic [15:0] rsp_val = 16'h0;
  time         t_last = 0;
  time         t_per = 0;

  // PHY responder: records the line at each rising MDC edge
  always @(posedge mdc) begin
    if (nrise == 1) t_per = $time - t_last;
    t_last   = $time;
    cap_bits = {cap_bits[62:0], mdio_o};
    cap_oe   = {cap_oe[62:0], mdio_oe};
    nrise    = nrise + 1;
  end

  // PHY responder: drives read data after each falling MDC edge
  always @(negedge mdc) begin
    if (nrise >= 48 && nrise < 64) mdio_i = rsp_val[63 - nrise];
    else mdio_i = 1'b1;
  end

  function automatic logic [63:0] exp_frame(bit wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    logic [1:0] opc;
    logic [1:0] ta;
    logic [15:0] dd;
    opc = wr ? 2'b01 : 2'b10;
    ta  = wr ? 2'b10 : 2'b00;
    dd  = wr ? d : 16'h0;
    return {32'hFFFF_FFFF, 2'b01, opc, phy, rg, ta, dd};
  endfunction

  function automatic logic [15:0] exp_ctrl(bit wr, logic [4:0] phy, logic [4:0] rg);
    return {1'b1, 1'b0, wr, phy, 3'b000, rg};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(bit a, logic [15:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr   = 1'b0;
    host_addr = 1'b0;
  endtask

  task automatic host_read(bit a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
    host_addr = 1'b0;
  endtask

  task automatic run_txn(bit wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] d,
                         logic [15:0] phy_val, bit intrude, logic [15:0] junk);
    logic [15:0] cw;
    logic [15:0] rd;
    logic [63:0] ef;
    int cnt;
    cw = {junk[15:14], wr, phy, junk[7:5], rg};
    rsp_val = phy_val;
    nrise = 0;
    mdio_i = 1'b1;
    if (wr) host_write(1'b1, d);
    host_write(1'b0, cw);
    cnt = 1;
    host_read(1'b0, rd);
    chk(rd[15] == 1'b0, "R1 idle flag low after launch", rd, 0);
    while (1) begin
      if (intrude && cnt == 300) begin
        host_addr = 1'b0; host_wdata = ~cw; host_wr = 1'b1;
        @(negedge clk); cnt++;
        host_addr = 1'b1; host_wdata = ~d;
        @(negedge clk); cnt++;
        host_wr = 1'b0; host_addr = 1'b0;
      end
      @(negedge clk);
      cnt++;
      host_read(1'b0, rd);
      if (rd[15] || cnt > TXN_CYCLES + 50) break;
    end
    chk(cnt == TXN_CYCLES + 1, "R7 transfer length", cnt, TXN_CYCLES + 1);
    chk(nrise == 64, "R3 rising edge count", nrise, 64);
    ef = exp_frame(wr, phy, rg, d);
    if (wr) begin
      chk(cap_bits == ef, "R3 write frame bits", cap_bits, ef);
      chk(cap_oe == {64{1'b1}}, "R4 write frame driven throughout", cap_oe, {64{1'b1}});
      host_read(1'b1, rd);
      chk(rd == d, intrude ? "R9 data write ignored while busy" : "R9 data word kept",
          rd, d);
    end else begin
      chk(cap_bits[63:18] == ef[63:18], "R3 read frame header", cap_bits[63:18], ef[63:18]);
      chk(cap_oe == {{46{1'b1}}, 18'b0}, "R4 read turnaround and data released",
          cap_oe, {{46{1'b1}}, 18'b0});
      host_read(1'b1, rd);
      chk(rd == phy_val, "R5 captured read data", rd, phy_val);
    end
    host_read(1'b0, rd);
    chk(rd == exp_ctrl(wr, phy, rg),
        intrude ? "R8 control write ignored while busy" : "R2 control readback",
        rd, exp_ctrl(wr, phy, rg));
    chk(t_per == 2 * HALF * 20, "R6 MDC period ns", t_per, 2 * HALF * 20);
  endtask

  initial begin
    logic [15:0] rd;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    host_read(1'b0, rd);
    chk(rd == 16'h8000, "R1 idle flag at reset", rd, 16'h8000);
    host_read(1'b1, rd);
    chk(rd == 16'h0000, "R9 data word reset", rd, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R4 lines released in reset", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R6 MDC rests low when idle", {mdc, mdio_oe}, 0);

    host_write(1'b1, 16'hA5C3);
    host_read(1'b1, rd);
    chk(rd == 16'hA5C3, "R9 idle data write readback", rd, 16'hA5C3);

    run_txn(1'b1, 5'd0, 5'd0, 16'h0000, 16'h0, 1'b0, 16'h0000);
    run_txn(1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0, 1'b0, 16'hC0E0);
    run_txn(1'b0, 5'd1, 5'd2, 16'h0, 16'h8001, 1'b0, 16'h0000);
    run_txn(1'b0, 5'd31, 5'd31, 16'h0, 16'hFFFF, 1'b0, 16'hFFFF);
    run_txn(1'b0, 5'd16, 5'd1, 16'h0, 16'h0000, 1'b0, 16'h0000);
    run_txn(1'b1, 5'd10, 5'd21, 16'h1234, 16'h0, 1'b1, 16'h0000);
    run_txn(1'b0, 5'd7, 5'd9, 16'h5A5A, 16'hBEEF, 1'b1, 16'h0000);

    for (int i = 0; i < 16; i++) begin
      run_txn(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
              16'($urandom), 16'($urandom), 1'($urandom_range(0, 3) == 0), 16'($urandom));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule